// File: doc/BRIEF.md
# Serial Address Receive Filter

This block sits between a character decoder and a receive FIFO. It decides, one character at a time, whether each decoded character goes into the FIFO. An address marker is the control character whose value equals `MARK_CODE`, 0xFD by default. The data character after a marker is an address. The filter compares that address with a stored station address, then opens or closes a gate. The gate holds that state for every following character until the next marker. The compare works in one of two ways. In domain mode, any bit that is set in both values counts as a match. In exact mode, the two values must be equal.

The incoming stream uses valid/ready. The filter adds no buffering. Its `in_rdy` output is `out_rdy` passed straight through. A character counts as consumed in a cycle where `in_vld` and `out_rdy` are both high. `acc_stb` is the FIFO write enable for that same cycle and for the character currently on `in_data`. It only rises for a consumed character, so the FIFO's readiness is the only back-pressure. When `filt_en` is low, the filter passes every consumed character.

Top module: `saf_filter`

## Requirements
- R1: After reset with `filt_en` high, `gate_open` is 0 and a consumed data character gives `acc_stb` = 0 until an address opens the gate.
- R2: With `filt_en` high, a marker (`in_ctl`=1, `in_data`=`MARK_CODE`) and the data character right after it are never accepted.
- R3: In domain mode (`cfg_ucast`=0), the address matches when the bitwise AND of the received address and the stored address is nonzero.
- R4: In exact mode (`cfg_ucast`=1), the address matches only when it equals the stored address.
- R5: After a matching address, every consumed character, control or data, is accepted until the next marker, and `gate_open` reads 1.
- R6: After a non-matching address, every consumed character is discarded until the next marker, and `gate_open` reads 0.
- R7: With `filt_en` low, every consumed character is accepted, markers included, and `gate_open` reads 1.
- R8: A `cfg_wr` pulse loads `cfg_addr`/`cfg_ucast` only while `in_vld` is low and is otherwise ignored. Each compare uses the configuration held when its marker was consumed.
- R9: A control character that is not a marker, arriving where an address is expected, cancels the compare. The gate keeps its state, and that character is accepted exactly when the gate is open.
- R10: `in_rdy` always equals `out_rdy`. `acc_stb` is high only when `in_vld` and `out_rdy` are both high. A character offered while `out_rdy` is low has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| filt_en | input | 1 | Turns address filtering on |
| cfg_wr | input | 1 | Loads the address/mode configuration |
| cfg_addr | input | DW | Station address to store |
| cfg_ucast | input | 1 | Mode to store: 0 domain, 1 exact |
| in_vld | input | 1 | Character on the input is valid |
| in_rdy | output | 1 | Filter can take a character (equals out_rdy) |
| in_ctl | input | 1 | 1 = control character, 0 = data |
| in_data | input | DW | Character value |
| out_rdy | input | 1 | FIFO can accept a write |
| acc_stb | output | 1 | Write the current character into the FIFO |
| gate_open | output | 1 | Current accept state |

## Verification
The bench builds the filter with `DW`=4 and `MARK_CODE`=4'hD. At that width it can try every stored address against every received address in both modes, 512 compares in all. It checks that the marker and address are dropped and that the gate decision holds for the next character. Directed sequences cover the write guard on the configuration, the snapshot taken at the marker, a control character in the address slot, bypass, and stalls from the FIFO side.

// File: rtl/saf_pkg.sv
package saf_pkg;
  typedef enum logic {
    CMP_DOMAIN = 1'b0,
    CMP_EXACT  = 1'b1
  } cmp_mode_e;
endpackage

// File: rtl/saf_cfg_reg.sv
module saf_cfg_reg
  import saf_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_wr,
  input  logic          in_vld,
  input  logic [DW-1:0] cfg_addr,
  input  logic          cfg_ucast,
  output logic [DW-1:0] stn_addr,
  output cmp_mode_e     stn_mode
);
  // writes land only while the stream is idle
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stn_addr <= '0;
      stn_mode <= CMP_DOMAIN;
    end else if (cfg_wr && !in_vld) begin
      stn_addr <= cfg_addr;
      stn_mode <= cmp_mode_e'(cfg_ucast);
    end
  end
endmodule

// File: rtl/saf_addr_cmp.sv
module saf_addr_cmp
  import saf_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic [DW-1:0] ref_addr,
  input  cmp_mode_e     ref_mode,
  input  logic [DW-1:0] rx_addr,
  output logic          hit
);
  logic [DW-1:0] both_set;
  logic [DW-1:0] same_bit;

  for (genvar b = 0; b < DW; b++) begin : g_bit
    assign both_set[b] = ref_addr[b] & rx_addr[b];
    assign same_bit[b] = ~(ref_addr[b] ^ rx_addr[b]);
  end

  always_comb begin
    unique case (ref_mode)
      CMP_DOMAIN: hit = |both_set;
      CMP_EXACT:  hit = &same_bit;
      default:    hit = 1'b0;
    endcase
  end
endmodule

// File: rtl/saf_gate_fsm.sv
module saf_gate_fsm
  import saf_pkg::*;
#(
  parameter int          DW        = 8,
  parameter logic [DW-1:0] MARK_CODE = 8'hFD
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          filt_en,
  input  logic          take,
  input  logic          in_ctl,
  input  logic [DW-1:0] in_data,
  input  logic [DW-1:0] stn_addr,
  input  cmp_mode_e     stn_mode,
  input  logic          hit,
  output logic [DW-1:0] snap_addr,
  output cmp_mode_e     snap_mode,
  output logic          acc_stb,
  output logic          gate_open
);
  logic armed;
  logic gate_q;
  logic is_mark;

  assign is_mark = in_ctl && (in_data == MARK_CODE);

  always_comb begin
    acc_stb = 1'b0;
    if (!filt_en)                acc_stb = take;
    else if (take) begin
      if (is_mark)               acc_stb = 1'b0;
      else if (armed && !in_ctl) acc_stb = 1'b0;
      else                       acc_stb = gate_q;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      armed     <= 1'b0;
      gate_q    <= 1'b0;
      snap_addr <= '0;
      snap_mode <= CMP_DOMAIN;
    end else if (filt_en && take) begin
      if (is_mark) begin
        armed     <= 1'b1;
        snap_addr <= stn_addr;
        snap_mode <= stn_mode;
      end else if (armed) begin
        armed <= 1'b0;
        if (!in_ctl) gate_q <= hit;
      end
    end
  end

  assign gate_open = !filt_en || gate_q;
endmodule

// File: rtl/saf_filter.sv
module saf_filter
  import saf_pkg::*;
#(
  parameter int            DW        = 8,
  parameter logic [DW-1:0] MARK_CODE = 8'hFD
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          filt_en,
  input  logic          cfg_wr,
  input  logic [DW-1:0] cfg_addr,
  input  logic          cfg_ucast,
  input  logic          in_vld,
  output logic          in_rdy,
  input  logic          in_ctl,
  input  logic [DW-1:0] in_data,
  input  logic          out_rdy,
  output logic          acc_stb,
  output logic          gate_open
);
  logic [DW-1:0] stn_addr;
  cmp_mode_e     stn_mode;
  logic [DW-1:0] snap_addr;
  cmp_mode_e     snap_mode;
  logic          hit;
  logic          take;

  assign in_rdy = out_rdy;
  assign take   = in_vld && out_rdy;

  saf_cfg_reg #(.DW(DW)) u_cfg (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .in_vld(in_vld),
    .cfg_addr(cfg_addr), .cfg_ucast(cfg_ucast),
    .stn_addr(stn_addr), .stn_mode(stn_mode)
  );

  saf_addr_cmp #(.DW(DW)) u_cmp (
    .ref_addr(snap_addr), .ref_mode(snap_mode),
    .rx_addr(in_data), .hit(hit)
  );

  saf_gate_fsm #(.DW(DW), .MARK_CODE(MARK_CODE)) u_fsm (
    .clk(clk), .rst_n(rst_n), .filt_en(filt_en), .take(take),
    .in_ctl(in_ctl), .in_data(in_data),
    .stn_addr(stn_addr), .stn_mode(stn_mode), .hit(hit),
    .snap_addr(snap_addr), .snap_mode(snap_mode),
    .acc_stb(acc_stb), .gate_open(gate_open)
  );
endmodule

// File: rtl/saf_filter_chk.sv
module saf_filter_chk #(
  parameter int            DW        = 8,
  parameter logic [DW-1:0] MARK_CODE = 8'hFD
) (
  input logic          clk,
  input logic          rst_n,
  input logic          filt_en,
  input logic          in_vld,
  input logic          in_rdy,
  input logic          in_ctl,
  input logic [DW-1:0] in_data,
  input logic          out_rdy,
  input logic          acc_stb,
  input logic          gate_open
);
  logic took, mark_seen, pend;
  assign took      = in_vld && out_rdy;
  assign mark_seen = in_ctl && (in_data == MARK_CODE);

  always_ff @(posedge clk) begin
    if (!rst_n)                      pend <= 1'b0;
    else if (filt_en && took)        pend <= mark_seen;
  end

  // R10
  rdy_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_rdy == out_rdy);
  // R10
  strobe_hs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_stb |-> (in_vld && out_rdy));
  // R2
  marker_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (filt_en && took && mark_seen) |-> !acc_stb);
  // R2
  addr_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (filt_en && took && pend && !in_ctl) |-> !acc_stb);
  // R7
  bypass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!filt_en && took) |-> (acc_stb && gate_open));
  // R6
  closed_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (filt_en && !gate_open && took) |-> !acc_stb);
  // R5
  gate_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (filt_en && $past(filt_en) && !$past(took && pend)) |-> $stable(gate_open));
endmodule

bind saf_filter saf_filter_chk #(.DW(DW), .MARK_CODE(MARK_CODE)) u_chk (
  .clk(clk), .rst_n(rst_n), .filt_en(filt_en), .in_vld(in_vld),
  .in_rdy(in_rdy), .in_ctl(in_ctl), .in_data(in_data),
  .out_rdy(out_rdy), .acc_stb(acc_stb), .gate_open(gate_open)
);

// File: tb/sim_saf_filter.sv
`timescale 1ns/1ps
module sim_saf_filter;
  localparam int DW = 4;
  localparam logic [DW-1:0] MK = 4'hD;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic filt_en = 1'b1;
  logic cfg_wr = 1'b0;
  logic [DW-1:0] cfg_addr = '0;
  logic cfg_ucast = 1'b0;
  logic in_vld = 1'b0;
  logic in_rdy;
  logic in_ctl = 1'b0;
  logic [DW-1:0] in_data = '0;
  logic out_rdy = 1'b1;
  logic acc_stb;
  logic gate_open;

  int total = 0;
  int fails = 0;

  always #10 clk = ~clk;

  saf_filter #(.DW(DW), .MARK_CODE(MK)) u0 (
    .clk(clk), .rst_n(rst_n), .filt_en(filt_en), .cfg_wr(cfg_wr),
    .cfg_addr(cfg_addr), .cfg_ucast(cfg_ucast), .in_vld(in_vld),
    .in_rdy(in_rdy), .in_ctl(in_ctl), .in_data(in_data),
    .out_rdy(out_rdy), .acc_stb(acc_stb), .gate_open(gate_open)
  );

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // offer one character; returns acc_stb seen for it
  task automatic put(input logic ctl, input logic [DW-1:0] d, output logic acc);
    @(negedge clk);
    in_vld = 1'b1; in_ctl = ctl; in_data = d;
    #1 acc = acc_stb;
    @(posedge clk); #1;
    in_vld = 1'b0; in_ctl = 1'b0;
  endtask

  task automatic cfg(input logic [DW-1:0] a, input logic m);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_addr = a; cfg_ucast = m;
    @(posedge clk); #1;
    cfg_wr = 1'b0;
  endtask

  initial begin
    #4_000_000;
    total++; fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    logic a;
    logic exp;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R1 reset state
    @(negedge clk);
    chk("R1 gate_open after reset", gate_open, 0);
    put(1'b0, 4'h3, a);
    chk("R1 data before any address", a, 0);

    // R3 / R4 exhaustive sweep
    for (int m = 0; m < 2; m++)
      for (int r = 0; r < 16; r++)
        for (int x = 0; x < 16; x++) begin
          cfg(r[DW-1:0], m[0]);
          exp = (m == 1) ? (x == r) : ((x & r) != 0);
          put(1'b1, MK, a);
          chk("R2 marker dropped", a, 0);
          put(1'b0, x[DW-1:0], a);
          chk("R2 address dropped", a, 0);
          put(1'b0, 4'h5, a);
          chk(m ? "R4 exact compare" : "R3 domain compare", a, exp);
          chk(exp ? "R5 gate_open after hit" : "R6 gate_open after miss",
              gate_open, exp);
        end

    // R5 gate holds for data and control characters
    cfg(4'h6, 1'b1);
    put(1'b1, MK, a); put(1'b0, 4'h6, a);
    put(1'b1, 4'h2, a); chk("R5 control char through open gate", a, 1);
    put(1'b0, 4'hD, a); chk("R5 data char through open gate", a, 1);
    // R6 closed gate drops control characters too
    put(1'b1, MK, a); put(1'b0, 4'h7, a);
    put(1'b1, 4'h2, a); chk("R6 control char in closed gate", a, 0);
    put(1'b0, 4'h1, a); chk("R6 data char in closed gate", a, 0);

    // R8 write during valid ignored
    cfg(4'h3, 1'b1);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_addr = 4'h9; in_vld = 1'b1; in_ctl = 1'b0; in_data = 4'h0;
    @(posedge clk); #1;
    cfg_wr = 1'b0; in_vld = 1'b0;
    put(1'b1, MK, a); put(1'b0, 4'h3, a);
    put(1'b0, 4'h4, a); chk("R8 write under valid ignored", a, 1);
    // R8 snapshot at marker: change after marker does not affect compare
    put(1'b1, MK, a);
    cfg(4'hA, 1'b1);
    put(1'b0, 4'h3, a);
    put(1'b0, 4'h4, a); chk("R8 compare uses config at marker", a, 1);
    put(1'b1, MK, a); put(1'b0, 4'h3, a);
    put(1'b0, 4'h4, a); chk("R8 new config used at next marker", a, 0);

    // R9 control char in address slot, gate closed then open
    put(1'b1, MK, a);
    put(1'b1, 4'h1, a); chk("R9 ctrl in addr slot, closed", a, 0);
    chk("R9 gate unchanged closed", gate_open, 0);
    put(1'b1, MK, a); put(1'b0, 4'hA, a);
    put(1'b1, MK, a);
    put(1'b1, 4'h1, a); chk("R9 ctrl in addr slot, open", a, 1);
    put(1'b0, 4'h2, a); chk("R9 gate still open", a, 1);

    // R10 stall from FIFO side
    out_rdy = 1'b0;
    @(negedge clk); #1 chk("R10 in_rdy follows out_rdy low", in_rdy, 0);
    put(1'b1, MK, a); chk("R10 no strobe while stalled", a, 0);
    out_rdy = 1'b1;
    put(1'b0, 4'h2, a); chk("R10 stalled marker had no effect", a, 1);
    chk("R10 in_rdy follows out_rdy high", in_rdy, 1);

    // R7 bypass
    put(1'b1, MK, a); put(1'b0, 4'h0, a);
    chk("R6 precondition closed", gate_open, 0);
    filt_en = 1'b0;
    @(negedge clk); #1 chk("R7 gate_open in bypass", gate_open, 1);
    put(1'b1, MK, a); chk("R7 marker accepted", a, 1);
    put(1'b0, 4'h0, a); chk("R7 data accepted", a, 1);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule